// File: doc/BRIEF.md
# Two-Wire Control Port for a Voltage-Output DAC

This block is the digital front end of a single-channel voltage-output DAC on a two-wire (I2C) bus. It oversamples the clock and data lines with the system clock and finds bus conditions: START, repeated START and STOP. It answers a 7-bit address whose upper five bits are fixed and whose two low bits come from a pin-strap input. A bus master programs the converter by sending a 16-bit word as two bytes. The word carries a 2-bit power-down selection and a left-justified conversion code.

The block holds the code and the power-down selection in separate registers. Both registers change together, and only after the master has delivered the whole word. A read transfer returns both fields packed into two bytes. The alignment of this readback differs from the alignment of the write word. The SDA output is a single active-low enable, which an open-drain pad uses to pull the line low. The code width is a parameter and may be 8, 10 or 12 bits. The analog converter, the output loads and the glitch filtering of the pads sit outside this block.

Top module: `dac_serial_port`

## Requirements
- R1: The slave acknowledges an address byte whose 7-bit address equals {00011, addr_sel[1:0]}. It follows the address byte as a write when the last bit is 0 and as a read when the last bit is 1. When addr_sel changes, the slave answers the new address and stops answering the old one.
- R2: An address byte with any other address gets no acknowledge. This includes general call (all zeros) and the 10-bit prefix 11110xx. The bytes that follow it in the same transfer get no acknowledge and change no output.
- R3: SDA is driven only by pulling it low, with sda_oe_n low meaning the pad pulls low. sda_oe_n changes only while SCL is low.
- R4: The write word arrives MSB first, as a high byte and then a low byte. Bits 13:12 become pd_mode. The code is taken from bit 11 downward, CODE_W bits wide. Bits 15:14 and the low bits below the code are ignored.
- R5: In a write, the slave pulls SDA low during the ninth clock of the address byte, of the first data byte and of the second data byte.
- R6: dac_code and pd_mode update together, and only after the acknowledge of the second data byte. At that moment wr_strobe is high for exactly one clock. Neither output changes in any cycle without wr_strobe.
- R7: If a STOP or a repeated START arrives before the second data byte has been acknowledged, dac_code and pd_mode keep their values and no strobe occurs. A repeated START starts a new address phase.
- R8: After reset, dac_code is zero, pd_mode is 00, wr_strobe is low and SDA is released. These values hold until a complete write.
- R9: pd_mode encodings: 00 = active, 01 = output tied to ground through 1 kΩ, 10 = output tied to ground through 100 kΩ, 11 = output floating. A power-down selection never blanks dac_code, which keeps the written code.
- R10: The first readback byte is {pd_mode, the top six code bits}. The second readback byte holds the remaining code bits followed by zero padding.
- R11: In a read, a master ACK after a byte makes the slave send the next byte. A master NACK makes the slave release SDA until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 2 | Low two bits of the slave address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_n | output | 1 | Low makes the pad pull SDA low |
| dac_code | output | CODE_W | Conversion code for the converter |
| pd_mode | output | 2 | Power-down selection |
| wr_strobe | output | 1 | One-clock pulse when a new word is applied |

## Verification
Some properties are checked on every cycle. The outputs change only together with the one-clock strobe, and the strobe never lasts two clocks. The data-line enable moves only while the clock line is low, and reset leaves a zero code in the active mode. Other behaviour only directed bus traffic can show: which addresses are acknowledged, how the fields of the word are unpacked and how the readback is packed, and that aborted or foreign transfers leave the registers untouched. The bench checks these through the acknowledge bits and the readback bytes it sees on the bus.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 16;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_WDATA,
      PH_RDATA,
      PH_SKIP
   } phase_e;

   typedef enum logic [1:0] {
      PD_ACTIVE   = 2'b00,
      PD_GND_1K   = 2'b01,
      PD_GND_100K = 2'b10,
      PD_FLOAT    = 2'b11
   } pd_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
   } busev_t;
endpackage

// File: rtl/dsp_line_sync.sv
module dsp_line_sync
   import dacif_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   scl_i,
   input  logic   sda_i,
   output logic   sda_lvl,
   output busev_t ev
);
   logic [STAGES-1:0] scl_ff, sda_ff;
   logic scl_q, sda_q, scl_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_lvl = scl_ff[STAGES-1];
   assign sda_lvl = sda_ff[STAGES-1];

   always_comb begin
      ev.start = scl_lvl & scl_q & sda_q & ~sda_lvl;
      ev.stop  = scl_lvl & scl_q & ~sda_q & sda_lvl;
      ev.rise  = scl_lvl & ~scl_q;
      ev.fall  = ~scl_lvl & scl_q;
   end
endmodule

// File: rtl/dsp_xfer_fsm.sv
module dsp_xfer_fsm
   import dacif_pkg::*;
#(
   parameter logic [4:0] ADDR_HI = 5'b00011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  busev_t            ev,
   input  logic              sda_lvl,
   input  logic [1:0]        addr_sel,
   input  logic [WORD_W-1:0] rb_word,
   output logic              commit,
   output logic [WORD_W-1:0] wr_word,
   output logic              drive_low
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   phase_e            ph;
   logic [CNT_W-1:0]  nbits;
   logic              in_ack, addr_slot, byte_sel, master_ack;
   logic [BYTE_W-1:0] sh, hi_byte, tx, next_byte;
   logic [6:0]        own_addr;
   logic              active;

   assign own_addr  = {ADDR_HI, addr_sel};
   assign next_byte = byte_sel ? rb_word[BYTE_W-1:0] : rb_word[WORD_W-1:BYTE_W];
   assign active    = (ph != PH_IDLE) && (ph != PH_SKIP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph         <= PH_IDLE;
         nbits      <= '0;
         in_ack     <= 1'b0;
         addr_slot  <= 1'b0;
         byte_sel   <= 1'b0;
         master_ack <= 1'b0;
         sh         <= '0;
         hi_byte    <= '0;
         tx         <= '0;
         wr_word    <= '0;
         commit     <= 1'b0;
         drive_low  <= 1'b0;
      end else begin
         commit <= 1'b0;
         if (ev.start || ev.stop) begin
            ph        <= ev.start ? PH_ADDR : PH_IDLE;
            nbits     <= '0;
            in_ack    <= 1'b0;
            addr_slot <= 1'b0;
            byte_sel  <= 1'b0;
            drive_low <= 1'b0;
         end else if (active) begin
            if (ev.rise) begin
               if (!in_ack) begin
                  sh    <= {sh[BYTE_W-2:0], sda_lvl};
                  nbits <= nbits + 1'b1;
               end else begin
                  master_ack <= ~sda_lvl;
               end
            end else if (ev.fall) begin
               if (!in_ack && nbits == FULL) begin
                  in_ack <= 1'b1;
                  case (ph)
                     PH_ADDR: begin
                        if (sh[7:1] == own_addr) begin
                           drive_low <= 1'b1;
                           addr_slot <= 1'b1;
                           ph        <= sh[0] ? PH_RDATA : PH_WDATA;
                        end else begin
                           drive_low <= 1'b0;
                           ph        <= PH_SKIP;
                        end
                     end
                     PH_WDATA: begin
                        drive_low <= 1'b1;
                        if (!byte_sel) hi_byte <= sh;
                     end
                     default: drive_low <= 1'b0;
                  endcase
               end else if (in_ack) begin
                  in_ack    <= 1'b0;
                  nbits     <= '0;
                  drive_low <= 1'b0;
                  addr_slot <= 1'b0;
                  if (ph == PH_WDATA && !addr_slot) begin
                     if (!byte_sel) begin
                        byte_sel <= 1'b1;
                     end else begin
                        commit  <= 1'b1;
                        wr_word <= {hi_byte, sh};
                        ph      <= PH_SKIP;
                     end
                  end else if (ph == PH_RDATA) begin
                     if (addr_slot || master_ack) begin
                        drive_low <= ~next_byte[BYTE_W-1];
                        tx        <= {next_byte[BYTE_W-2:0], 1'b0};
                        byte_sel  <= ~byte_sel;
                     end else begin
                        ph <= PH_SKIP;
                     end
                  end
               end else if (ph == PH_RDATA && nbits != '0) begin
                  drive_low <= ~tx[BYTE_W-1];
                  tx        <= {tx[BYTE_W-2:0], 1'b0};
               end
            end
         end
      end
   end
endmodule

// File: rtl/dsp_dac_regs.sv
module dsp_dac_regs
   import dacif_pkg::*;
#(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [WORD_W-1:0] wr_word,
   output logic [CODE_W-1:0] dac_code,
   output logic [1:0]        pd_mode,
   output logic              wr_strobe,
   output logic [WORD_W-1:0] rb_word
);
   localparam int CODE_TOP = 11;
   localparam int PAD_W    = WORD_W - 2 - CODE_W;

   pd_e               pd_q;
   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q    <= '0;
         pd_q      <= PD_ACTIVE;
         wr_strobe <= 1'b0;
      end else begin
         wr_strobe <= commit;
         if (commit) begin
            code_q <= wr_word[CODE_TOP -: CODE_W];
            pd_q   <= pd_e'(wr_word[13:12]);
         end
      end
   end

   assign dac_code = code_q;
   assign pd_mode  = pd_q;
   assign rb_word  = {pd_q, code_q, {PAD_W{1'b0}}};

   logic unused_hi;
   assign unused_hi = ^wr_word[15:14];

   generate
      if (CODE_W < CODE_TOP + 1) begin : g_lo_free
         logic unused_lo;
         assign unused_lo = ^wr_word[CODE_TOP-CODE_W:0];
      end
   endgenerate
endmodule

// File: rtl/dac_serial_port.sv
module dac_serial_port
   import dacif_pkg::*;
#(
   parameter int         CODE_W      = 12,
   parameter logic [4:0] ADDR_HI     = 5'b00011,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr_sel,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_n,
   output logic [CODE_W-1:0] dac_code,
   output logic [1:0]        pd_mode,
   output logic              wr_strobe
);
   generate
      if (CODE_W != 8 && CODE_W != 10 && CODE_W != 12) begin : g_bad_width
         $error("dac_serial_port: CODE_W must be 8, 10 or 12");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dac_serial_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   busev_t            ev;
   logic              sda_lvl, commit, drive_low;
   logic [WORD_W-1:0] wr_word, rb_word;

   dsp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_lvl(sda_lvl), .ev(ev)
   );

   dsp_xfer_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
      .clk(clk), .rst_n(rst_n), .ev(ev), .sda_lvl(sda_lvl),
      .addr_sel(addr_sel), .rb_word(rb_word), .commit(commit),
      .wr_word(wr_word), .drive_low(drive_low)
   );

   dsp_dac_regs #(.CODE_W(CODE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .commit(commit), .wr_word(wr_word),
      .dac_code(dac_code), .pd_mode(pd_mode), .wr_strobe(wr_strobe),
      .rb_word(rb_word)
   );

   assign sda_oe_n = ~drive_low;
endmodule

// File: rtl/dac_serial_port_chk.sv
module dac_serial_port_chk #(
   parameter int CODE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe_n,
   input logic [CODE_W-1:0] dac_code,
   input logic [1:0]        pd_mode,
   input logic              wr_strobe
);
   AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dac_code == '0 && pd_mode == 2'b00 && !wr_strobe)); // R8

   AST_CODE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_code) |-> wr_strobe); // R6

   AST_PD_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pd_mode) |-> wr_strobe); // R6

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> !wr_strobe); // R6

   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_n) |-> !scl_i); // R3
endmodule

bind dac_serial_port dac_serial_port_chk #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_n(sda_oe_n),
   .dac_code(dac_code), .pd_mode(pd_mode), .wr_strobe(wr_strobe)
);

// File: tb/dac_serial_port_test.sv
module dac_serial_port_test;
   localparam int H = 8;
   localparam logic [4:0] HI = 5'b00011;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic [1:0]  addr_sel = 2'b01;
   logic        m_scl = 1'b1, m_sda = 1'b1;
   logic        sda_oe_n, wr_strobe;
   logic [11:0] dac_code;
   logic [1:0]  pd_mode;
   wire         sda_bus = m_sda & sda_oe_n;

   dac_serial_port uut (
      .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(m_scl),
      .sda_i(sda_bus), .sda_oe_n(sda_oe_n), .dac_code(dac_code),
      .pd_mode(pd_mode), .wr_strobe(wr_strobe)
   );

   int n_chk = 0, n_bad = 0, strobes = 0, oe_viol = 0;
   logic oe_prev = 1'b1;

   always @(negedge clk) begin
      if (wr_strobe) strobes++;
      if (rst_n && sda_oe_n !== oe_prev && m_scl) oe_viol++;
      oe_prev <= sda_oe_n;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic b_start();
      m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H);
      m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(2);
   endtask

   task automatic b_stop();
      m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
   endtask

   task automatic tx_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(2);
      end
      m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H/2);
      acked = (sda_bus == 1'b0);
      wt(H/2); m_scl = 1'b0; wt(2);
   endtask

   task automatic rx_byte(input logic give_ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wt(H); m_scl = 1'b1; wt(H/2); b[i] = sda_bus; wt(H/2); m_scl = 1'b0; wt(2);
      end
      m_sda = give_ack ? 1'b0 : 1'b1;
      wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(2);
      m_sda = 1'b1;
   endtask

   task automatic do_write(input logic [6:0] a, input logic [15:0] w,
                           output logic k0, output logic k1, output logic k2);
      b_start();
      tx_byte({a, 1'b0}, k0);
      tx_byte(w[15:8], k1);
      tx_byte(w[7:0], k2);
      b_stop();
   endtask

   function automatic logic [6:0] own();
      return {HI, addr_sel};
   endfunction

   task automatic t_reset();
      chk("R8 code after reset", 32'(dac_code), 0);
      chk("R8 pd after reset", 32'(pd_mode), 0);
      chk("R8 sda released", 32'(sda_oe_n), 1);
      chk("R8 no strobe", 32'(strobes), 0);
   endtask

   task automatic t_basic_write();
      logic k0, k1, k2; int s = strobes;
      do_write(own(), 16'h0ABC, k0, k1, k2);
      chk("R1 own address acked", 32'(k0), 1);
      chk("R5 first data byte acked", 32'(k1), 1);
      chk("R5 second data byte acked", 32'(k2), 1);
      chk("R4 code from bits 11:0", 32'(dac_code), 32'h0ABC);
      chk("R4 pd from bits 13:12", 32'(pd_mode), 0);
      chk("R6 one strobe per write", 32'(strobes - s), 1);
   endtask

   task automatic t_reserved_bits();
      logic k0, k1, k2;
      do_write(own(), 16'hF123, k0, k1, k2);
      chk("R4 reserved bits ignored, pd", 32'(pd_mode), 3);
      chk("R9 float mode keeps code", 32'(dac_code), 32'h123);
   endtask

   task automatic t_pd_modes();
      logic k0, k1, k2; logic [15:0] w;
      for (int m = 0; m < 4; m++) begin
         w = {2'b00, 2'(m), 12'h5A0 + 12'(m)};
         do_write(own(), w, k0, k1, k2);
         chk("R9 pd encoding", 32'(pd_mode), 32'(m));
         chk("R9 code retained with pd", 32'(dac_code), 32'(w[11:0]));
      end
   endtask

   task automatic t_foreign();
      logic k0, k1, k2; int s = strobes;
      logic [11:0] c = dac_code; logic [1:0] p = pd_mode;
      do_write({HI, ~addr_sel}, 16'h0111, k0, k1, k2);
      chk("R2 other select not acked", 32'(k0), 0);
      chk("R2 data after foreign address not acked", 32'(k1), 0);
      do_write(7'h00, 16'h0222, k0, k1, k2);
      chk("R2 general call not acked", 32'(k0), 0);
      do_write(7'b1111000, 16'h0333, k0, k1, k2);
      chk("R2 10-bit prefix not acked", 32'(k0), 0);
      chk("R2 code untouched", 32'(dac_code), 32'(c));
      chk("R2 pd untouched", 32'(pd_mode), 32'(p));
      chk("R2 no strobe", 32'(strobes - s), 0);
   endtask

   task automatic t_abort();
      logic k0, k1, k2; int s = strobes;
      logic [11:0] c = dac_code; logic [1:0] p = pd_mode;
      b_start(); tx_byte({own(), 1'b0}, k0); tx_byte(8'h2F, k1); b_stop();
      chk("R7 stop abort keeps code", 32'(dac_code), 32'(c));
      chk("R7 stop abort keeps pd", 32'(pd_mode), 32'(p));
      chk("R7 stop abort no strobe", 32'(strobes - s), 0);
      b_start(); tx_byte({own(), 1'b0}, k0); tx_byte(8'h1F, k1);
      b_start(); tx_byte({own(), 1'b0}, k0);
      chk("R7 repeated start address acked", 32'(k0), 1);
      tx_byte(8'h03, k1); tx_byte(8'h21, k2); b_stop();
      chk("R7 write after repeated start", 32'(dac_code), 32'h321);
      chk("R7 pd after repeated start", 32'(pd_mode), 0);
      chk("R7 only completed write strobes", 32'(strobes - s), 1);
   endtask

   task automatic t_readback();
      logic k0, k1, k2; logic [7:0] b1, b2, b3;
      do_write(own(), 16'h2ABC, k0, k1, k2);
      b_start(); tx_byte({own(), 1'b1}, k0);
      chk("R1 read address acked", 32'(k0), 1);
      rx_byte(1'b1, b1);
      rx_byte(1'b1, b2);
      rx_byte(1'b0, b3);
      chk("R10 first byte pd and code msbs", 32'(b1), 32'({2'b10, 6'b101010}));
      chk("R10 second byte code lsbs and pad", 32'(b2), 32'({6'b111100, 2'b00}));
      chk("R11 ack continues with first byte", 32'(b3), 32'(b1));
      chk("R11 released after nack", 32'(sda_oe_n), 1);
      b_stop();
      chk("R11 read leaves code", 32'(dac_code), 32'hABC);
   endtask

   task automatic t_addr_sel();
      logic k0, k1, k2;
      addr_sel = 2'b10; wt(4);
      do_write(7'b0001110, 16'h0777, k0, k1, k2);
      chk("R1 new select acked", 32'(k0), 1);
      chk("R1 write under new select", 32'(dac_code), 32'h777);
      do_write(7'b0001101, 16'h0888, k0, k1, k2);
      chk("R1 old select not acked", 32'(k0), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      wt(5);
      rst_n = 1'b1;
      wt(5);
      t_reset();
      t_basic_write();
      t_reserved_bits();
      t_pd_modes();
      t_foreign();
      t_abort();
      t_readback();
      t_addr_sel();
      chk("R3 sda enable moved only with scl low", 32'(oe_viol), 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule